// File: doc/BRIEF.md
# Perturb-and-Observe Maximum Power Point Tracking Sequencer

This block is the digital controller of a perturb-and-observe maximum power point tracker for an energy-harvesting DC-DC converter. It owns the bias code that sets the oscillator current and, through it, the switching frequency of the converter. A free-running round counter cuts time into tracking rounds of 2^ROUND_W clock cycles. In each round the sequencer wakes an analog power estimator, strobes a sample-and-hold to capture the present power, and steps the bias code once in the current search direction. It then lets the converter settle for a fixed gap, wakes the estimator again and strobes a comparator that sets the new power against the held one. From the comparator's answer it decides the direction for the next round. Outside these two short measurement windows the analog enables stay low, so the estimator draws no power.

The analog estimator, sample-and-hold, comparator and oscillator are outside the block. They appear only as the estimator enable, the two strobes, the comparator result input and the bias code output. The sequencer is a phase state machine with eight states, driven by the round counter value: `PH_IDLE` goes to `PH_WARM_A` when the counter wraps to zero. `PH_WARM_A` goes to `PH_SAMPLE` after WARM_CYC cycles. `PH_SAMPLE` goes to `PH_PERTURB`, and `PH_PERTURB` goes to `PH_SETTLE`, each after one cycle. `PH_SETTLE` goes to `PH_WARM_B` at counter value GAP_CYC+1. `PH_WARM_B` goes to `PH_COMPARE` after WARM_CYC cycles. `PH_COMPARE` goes to `PH_DECIDE`, and `PH_DECIDE` returns to `PH_IDLE`, each after one cycle. The parameters must satisfy WARM_CYC >= 1 and GAP_CYC >= WARM_CYC + 2.

Top module: `pno_mppt_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `bias_code` equals BIAS_INIT, `dir_up` is 1 (meaning upward), and `sh_strobe` and `cmp_strobe` are 0. `est_en` is also 0 during that first cycle, which is round cycle 0.
- R2: A round lasts exactly 2^ROUND_W cycles. Round cycle 0 is the first cycle after reset release. `sh_strobe` is high for one cycle per round, at round cycle WARM_CYC+1.
- R3: `est_en` is high exactly on round cycles 1 to WARM_CYC+1 and GAP_CYC+2 to GAP_CYC+WARM_CYC+2. It therefore rises WARM_CYC cycles before each strobe and stays high through it. It is low on every other cycle.
- R4: The bias code is stepped once per round, on the edge that ends round cycle WARM_CYC+2 (the perturbation cycle). The new value is visible from round cycle WARM_CYC+3. The step is +1 when `dir_up` is 1 and -1 when it is 0. `bias_code` changes at no other time.
- R5: `cmp_strobe` is high for one cycle per round, at round cycle GAP_CYC+WARM_CYC+2. That is exactly GAP_CYC cycles after the perturbation cycle and GAP_CYC+1 cycles after `sh_strobe`.
- R6: `cmp_gt` is sampled only on the edge that ends the cycle after `cmp_strobe`. A value of 1 (new power higher) keeps `dir_up`, and 0 inverts it. The new direction is visible from the following cycle. `cmp_gt` has no effect on any output in any other cycle.
- R7: `bias_code` never leaves the range BIAS_MIN to BIAS_MAX. An upward step at BIAS_MAX or a downward step at BIAS_MIN leaves the code unchanged.
- R8: When the direction is decided while `bias_code` equals BIAS_MAX, `dir_up` becomes 0 whatever `cmp_gt` says. At BIAS_MIN it becomes 1.
- R9: `sh_strobe` and `cmp_strobe` are never high together, and each is high only while `est_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_gt | input | 1 | Comparator result: 1 when the new power estimate exceeds the held one |
| est_en | output | 1 | Power-on enable for the analog power estimator |
| sh_strobe | output | 1 | One-cycle capture pulse for the sample-and-hold |
| cmp_strobe | output | 1 | One-cycle strobe for the comparator |
| bias_code | output | BIAS_W | Oscillator bias-current control word |
| dir_up | output | 1 | Present search direction: 1 up, 0 down |

## Verification
All timing is counted from round cycle 0, the first cycle after reset release. The enable and the strobes are Moore outputs of the phase register, so each is due in the very round cycle that R2, R3 and R5 name. The bias step is registered at the end of the perturbation cycle, so it is due one cycle later, in round cycle WARM_CYC+3. The direction update is registered at the end of the decide cycle, so it is due in round cycle GAP_CYC+WARM_CYC+4. The bench keeps a round-cycle index, advances its own bias and direction model at exactly those edges, and compares every output on every falling edge of each round. Random `cmp_gt` values are driven in every cycle, including those where they must be ignored.

// File: rtl/pno_mppt_pkg.sv
package pno_mppt_pkg;

    // Phases of one tracking round, in the order they occur
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WARM_A  = 3'd1,
        PH_SAMPLE  = 3'd2,
        PH_PERTURB = 3'd3,
        PH_SETTLE  = 3'd4,
        PH_WARM_B  = 3'd5,
        PH_COMPARE = 3'd6,
        PH_DECIDE  = 3'd7
    } phase_e;

endpackage

// File: rtl/pno_round_timer.sv
module pno_round_timer #(
    parameter int unsigned ROUND_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [ROUND_W-1:0] cyc
);

    // Free-running; wraps every 2^ROUND_W cycles to start a new round
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

endmodule

// File: rtl/pno_phase_fsm.sv
module pno_phase_fsm
    import pno_mppt_pkg::*;
#(
    parameter int unsigned ROUND_W  = 12,
    parameter int unsigned WARM_CYC = 4,
    parameter int unsigned GAP_CYC  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ROUND_W-1:0] cyc,
    output logic               est_en,
    output logic               sh_strobe,
    output logic               cmp_strobe,
    output logic               perturb_go,
    output logic               decide_go
);

    // Counter values at which a multi-cycle phase hands over
    localparam logic [ROUND_W-1:0] WARM_A_END = ROUND_W'(WARM_CYC);
    localparam logic [ROUND_W-1:0] SETTLE_END = ROUND_W'(GAP_CYC + 1);
    localparam logic [ROUND_W-1:0] WARM_B_END = ROUND_W'(GAP_CYC + WARM_CYC + 1);

    phase_e state_q;
    phase_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:    if (cyc == '0)        state_d = PH_WARM_A;
            PH_WARM_A:  if (cyc == WARM_A_END) state_d = PH_SAMPLE;
            PH_SAMPLE:                        state_d = PH_PERTURB;
            PH_PERTURB:                       state_d = PH_SETTLE;
            PH_SETTLE:  if (cyc == SETTLE_END) state_d = PH_WARM_B;
            PH_WARM_B:  if (cyc == WARM_B_END) state_d = PH_COMPARE;
            PH_COMPARE:                       state_d = PH_DECIDE;
            PH_DECIDE:                        state_d = PH_IDLE;
            default:                          state_d = PH_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        est_en     = 1'b0;
        sh_strobe  = 1'b0;
        cmp_strobe = 1'b0;
        perturb_go = 1'b0;
        decide_go  = 1'b0;
        unique case (state_q)
            PH_IDLE:    ;
            PH_WARM_A:  est_en = 1'b1;
            PH_SAMPLE: begin
                est_en    = 1'b1;
                sh_strobe = 1'b1;
            end
            PH_PERTURB: perturb_go = 1'b1;
            PH_SETTLE:  ;
            PH_WARM_B:  est_en = 1'b1;
            PH_COMPARE: begin
                est_en     = 1'b1;
                cmp_strobe = 1'b1;
            end
            PH_DECIDE:  decide_go = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/pno_track_core.sv
module pno_track_core #(
    parameter int unsigned BIAS_W    = 6,
    parameter int unsigned BIAS_MIN  = 0,
    parameter int unsigned BIAS_MAX  = 63,
    parameter int unsigned BIAS_INIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              perturb_go,
    input  logic              decide_go,
    input  logic              cmp_gt,
    output logic [BIAS_W-1:0] bias_code,
    output logic              dir_up
);

    localparam logic [BIAS_W-1:0] CODE_LO   = BIAS_W'(BIAS_MIN);
    localparam logic [BIAS_W-1:0] CODE_HI   = BIAS_W'(BIAS_MAX);
    localparam logic [BIAS_W-1:0] CODE_INIT = BIAS_W'(BIAS_INIT);

    logic [BIAS_W-1:0] bias_step;
    logic              dir_next;
    logic              at_hi;
    logic              at_lo;

    assign at_hi = (bias_code == CODE_HI);
    assign at_lo = (bias_code == CODE_LO);

    // Saturating up/down step
    always_comb begin
        if (dir_up) begin
            bias_step = at_hi ? bias_code : bias_code + 1'b1;
        end else begin
            bias_step = at_lo ? bias_code : bias_code - 1'b1;
        end
    end

    // Keep on gain, flip on loss; a range limit turns the search back
    always_comb begin
        dir_next = cmp_gt ? dir_up : ~dir_up;
        if (at_hi) begin
            dir_next = 1'b0;
        end else if (at_lo) begin
            dir_next = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bias_code <= CODE_INIT;
            dir_up    <= 1'b1;
        end else begin
            if (perturb_go) begin
                bias_code <= bias_step;
            end
            if (decide_go) begin
                dir_up <= dir_next;
            end
        end
    end

endmodule

// File: rtl/pno_mppt_seq.sv
module pno_mppt_seq #(
    parameter int unsigned ROUND_W   = 12,
    parameter int unsigned WARM_CYC  = 4,
    parameter int unsigned GAP_CYC   = 32,
    parameter int unsigned BIAS_W    = 6,
    parameter int unsigned BIAS_MIN  = 0,
    parameter int unsigned BIAS_MAX  = 63,
    parameter int unsigned BIAS_INIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_gt,
    output logic              est_en,
    output logic              sh_strobe,
    output logic              cmp_strobe,
    output logic [BIAS_W-1:0] bias_code,
    output logic              dir_up
);

    logic [ROUND_W-1:0] cyc;
    logic               perturb_go;
    logic               decide_go;

    pno_round_timer #(
        .ROUND_W (ROUND_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .cyc   (cyc)
    );

    pno_phase_fsm #(
        .ROUND_W  (ROUND_W),
        .WARM_CYC (WARM_CYC),
        .GAP_CYC  (GAP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc        (cyc),
        .est_en     (est_en),
        .sh_strobe  (sh_strobe),
        .cmp_strobe (cmp_strobe),
        .perturb_go (perturb_go),
        .decide_go  (decide_go)
    );

    pno_track_core #(
        .BIAS_W    (BIAS_W),
        .BIAS_MIN  (BIAS_MIN),
        .BIAS_MAX  (BIAS_MAX),
        .BIAS_INIT (BIAS_INIT)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .perturb_go (perturb_go),
        .decide_go  (decide_go),
        .cmp_gt     (cmp_gt),
        .bias_code  (bias_code),
        .dir_up     (dir_up)
    );

endmodule

// File: rtl/pno_mppt_seq_chk.sv
module pno_mppt_seq_chk #(
    parameter int unsigned ROUND_W   = 12,
    parameter int unsigned WARM_CYC  = 4,
    parameter int unsigned GAP_CYC   = 32,
    parameter int unsigned BIAS_W    = 6,
    parameter int unsigned BIAS_MIN  = 0,
    parameter int unsigned BIAS_MAX  = 63,
    parameter int unsigned BIAS_INIT = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_gt,
    input logic              est_en,
    input logic              sh_strobe,
    input logic              cmp_strobe,
    input logic [BIAS_W-1:0] bias_code,
    input logic              dir_up
);

    localparam logic [ROUND_W:0]   PERIOD  = (ROUND_W+1)'(1) << ROUND_W;
    localparam logic [ROUND_W:0]   CMP_OFS = (ROUND_W+1)'(GAP_CYC + 1);
    localparam logic [BIAS_W-1:0]  CODE_LO = BIAS_W'(BIAS_MIN);
    localparam logic [BIAS_W-1:0]  CODE_HI = BIAS_W'(BIAS_MAX);

    // Cycles since the last sample strobe, with a flag once one was seen
    logic [ROUND_W:0] since_sh;
    logic             seen_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_sh <= '0;
            seen_sh  <= 1'b0;
        end else if (sh_strobe) begin
            since_sh <= (ROUND_W+1)'(1);
            seen_sh  <= 1'b1;
        end else if (seen_sh && since_sh != '1) begin
            since_sh <= since_sh + 1'b1;
        end
    end

    logic [BIAS_W-1:0] bias_prev;
    logic              bias_moved_one;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bias_prev <= BIAS_W'(BIAS_INIT);
        end else begin
            bias_prev <= bias_code;
        end
    end

    assign bias_moved_one = (bias_code == bias_prev + 1'b1) || (bias_code == bias_prev - 1'b1);

    a_r2_round_period: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_strobe && seen_sh) |-> (since_sh == PERIOD));

    a_r5_compare_gap: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_strobe |-> (seen_sh && since_sh == CMP_OFS));

    a_r9_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_strobe && cmp_strobe));

    a_r9_strobe_powered: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_strobe || cmp_strobe) |-> est_en);

    a_r4_step_timing: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bias_code) |-> ($past(sh_strobe, 2) && bias_moved_one));

    a_r6_dir_timing: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_up) |-> $past(cmp_strobe, 2));

    a_r7_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bias_code >= CODE_LO) && (bias_code <= CODE_HI));

    a_r8_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmp_strobe, 2) && bias_code == CODE_HI) |-> !dir_up);

    a_r8_turn_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmp_strobe, 2) && bias_code == CODE_LO) |-> dir_up);

endmodule

bind pno_mppt_seq pno_mppt_seq_chk #(
    .ROUND_W   (ROUND_W),
    .WARM_CYC  (WARM_CYC),
    .GAP_CYC   (GAP_CYC),
    .BIAS_W    (BIAS_W),
    .BIAS_MIN  (BIAS_MIN),
    .BIAS_MAX  (BIAS_MAX),
    .BIAS_INIT (BIAS_INIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_gt     (cmp_gt),
    .est_en     (est_en),
    .sh_strobe  (sh_strobe),
    .cmp_strobe (cmp_strobe),
    .bias_code  (bias_code),
    .dir_up     (dir_up)
);

// File: tb/pno_mppt_seq_bench.sv
module pno_mppt_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ROUND_W    = 12;
    localparam int ROUND_LEN  = 1 << ROUND_W;
    localparam int WARM       = 4;
    localparam int GAP        = 32;
    localparam int BW         = 4;
    localparam int BMIN       = 2;
    localparam int BMAX       = 12;
    localparam int BINIT      = 10;
    localparam int ROUNDS     = 40;
    localparam int DIRECTED   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_gt = 1'b0;
    logic          est_en;
    logic          sh_strobe;
    logic          cmp_strobe;
    logic [BW-1:0] bias_code;
    logic          dir_up;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pno_mppt_seq #(
        .ROUND_W   (ROUND_W),
        .WARM_CYC  (WARM),
        .GAP_CYC   (GAP),
        .BIAS_W    (BW),
        .BIAS_MIN  (BMIN),
        .BIAS_MAX  (BMAX),
        .BIAS_INIT (BINIT)
    ) u_pno_mppt_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_gt     (cmp_gt),
        .est_en     (est_en),
        .sh_strobe  (sh_strobe),
        .cmp_strobe (cmp_strobe),
        .bias_code  (bias_code),
        .dir_up     (dir_up)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_est(input int c);
        return (c >= 1 && c <= WARM + 1) || (c >= GAP + 2 && c <= GAP + WARM + 2);
    endfunction

    function automatic bit exp_sh(input int c);
        return c == WARM + 1;
    endfunction

    function automatic bit exp_cmp(input int c);
        return c == GAP + WARM + 2;
    endfunction

    function automatic int step_bias(input int b, input bit up);
        if (up) return (b == BMAX) ? b : b + 1;
        return (b == BMIN) ? b : b - 1;
    endfunction

    function automatic bit next_dir(input int b, input bit up, input bit gt);
        bit nd;
        nd = gt ? up : !up;
        if (b == BMAX) nd = 1'b0;
        else if (b == BMIN) nd = 1'b1;
        return nd;
    endfunction

    initial begin
        int  m_bias;
        bit  m_dir;
        bit  hit_top;
        bit  hit_bottom;
        void'($urandom(32'd20250611));
        m_bias     = BINIT;
        m_dir      = 1'b1;
        hit_top    = 1'b0;
        hit_bottom = 1'b0;

        // R1: reset state while reset is held
        repeat (3) @(negedge clk);
        chk("R1", "bias_code in reset", int'(bias_code), BINIT);
        chk("R1", "dir_up in reset", int'(dir_up), 1);
        chk("R1", "est_en in reset", int'(est_en), 0);
        chk("R1", "sh_strobe in reset", int'(sh_strobe), 0);
        chk("R1", "cmp_strobe in reset", int'(cmp_strobe), 0);

        rst_n = 1'b1;
        for (int r = 0; r < ROUNDS; r++) begin
            for (int c = 0; c < ROUND_LEN; c++) begin
                // R2 R3 R5 R9: phase outputs due in the named round cycle
                chk("R3", $sformatf("est_en r%0d c%0d", r, c), int'(est_en), int'(exp_est(c)));
                chk("R2", $sformatf("sh_strobe r%0d c%0d", r, c), int'(sh_strobe), int'(exp_sh(c)));
                chk("R5", $sformatf("cmp_strobe r%0d c%0d", r, c), int'(cmp_strobe), int'(exp_cmp(c)));
                // R4 R7: bias code; R6 R8: direction
                chk((m_bias == BMAX || m_bias == BMIN) ? "R7" : "R4",
                    $sformatf("bias_code r%0d c%0d", r, c), int'(bias_code), m_bias);
                chk((c == GAP + WARM + 4 && (m_bias == BMAX || m_bias == BMIN)) ? "R8" : "R6",
                    $sformatf("dir_up r%0d c%0d", r, c), int'(dir_up), int'(m_dir));

                // Drive the comparator result for this cycle
                if (c == GAP + WARM + 3) begin
                    cmp_gt = (r < DIRECTED) ? 1'b1 : 1'($urandom % 2);
                end else begin
                    cmp_gt = 1'($urandom % 2);
                end

                // Model the edge that ends this cycle
                if (c == WARM + 2) begin
                    m_bias = step_bias(m_bias, m_dir);
                end
                if (c == GAP + WARM + 3) begin
                    if (m_bias == BMAX) hit_top = 1'b1;
                    if (m_bias == BMIN) hit_bottom = 1'b1;
                    m_dir = next_dir(m_bias, m_dir, cmp_gt);
                end
                @(negedge clk);
            end
        end

        // R8: the directed rounds must have reached both limits
        chk("R8", "top limit reached", int'(hit_top), 1);
        chk("R8", "bottom limit reached", int'(hit_bottom), 1);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule